// File: doc/BRIEF.md
# Packet Key-Selection Unit

This unit sits beside a transport-stream parser and decides, once per packet, whether the packet payload goes through the cipher and which key the cipher uses. It holds a table of six packet identifiers. Each entry carries a three-bit pointer to one of six odd/even key pairs. The last entry also has a per-bit compare mask, so one entry can cover a group of identifiers. A separate default key can be selected directly by the header's scrambling field, whatever the identifier is.

The parser presents the header fields of each packet as one pulse: the 13-bit identifier, the two transport scrambling bits and the payload-start flag. Later in a payload-start packet it can present the two scrambling bits from the elementary-stream header. The unit registers its decision one clock after each pulse and holds it until the next pulse. It also produces the rewritten scrambling bits for the outgoing headers. For every table entry it keeps the last scrambling bits seen, so that they can be observed. The table is loaded through a small word-write port.

Top module: `pid_cw_selector`

## Requirements
- R1: After reset every entry has pointer 111 and identifier 0, the mask is all ones, the elementary-stream flags and the default-valid flag are 0, and all outputs are 0. In this state no packet is descrambled.
- R2: Entries 0 to 4 match only on an exact 13-bit identifier. Entry 5 compares only the bits whose mask bit is 1, so a mask bit of 0 is "don't care". Config word layout: address 0-5 writes {pointer[15:13], identifier[12:0]} of that entry, address 6 writes the mask [12:0], and address 7 writes the default-valid flag [15] and the per-entry elementary-stream flags [5:0].
- R3: A pointer of 0 to 5 selects key pair 0 to 5 (key_sel = pointer). An entry whose pointer is 6 or 7 takes no part in selection, so a lower-priority matching entry may win instead.
- R4: When several enabled entries match, the lowest-numbered entry wins.
- R5: Transport scrambling bits 00 mean clear (dsc_en = 0). Bits 10 select the even key (key_odd = 0) and bits 11 select the odd key (key_odd = 1) of the winning entry's pair.
- R6: Transport scrambling bits 01 select the default key (key_sel = 6, key_odd = 0) for any identifier, even one that is not in the table, whatever the pointers are. When the default-valid flag is 0, such a packet is not descrambled.
- R7: When the transport bits are 00, the winning entry's elementary-stream flag is set, and the stored elementary-stream bits for that entry are 10 or 11, the payload is descrambled at that level (dsc_pes = 1) with the entry's pair, even for 10 and odd for 11. Stored bits of 00 or 01 mean clear. The default key is never used at this level, and transport-level scrambling always takes precedence.
- R8: Elementary-stream bits presented during a payload-start packet are stored for every matched entry whose flag is set, and they appear on pes_sc_capt (entry i at bits [2i+1:2i]). In a payload-start packet at this level the decision stays clear until those bits arrive, and then it is updated one clock later. Packets without a payload start use the stored bits.
- R9: The transport scrambling bits of a packet are stored for every matched entry, whatever its pointer, and they appear on ts_sc_capt (entry i at bits [2i+1:2i]).
- R10: tsc_out is 00 when the packet is descrambled at transport level and is the incoming bits otherwise. pes_sc_out is 00 when the payload is descrambled at elementary-stream level and is the incoming elementary-stream bits otherwise.
- R11: The decision outputs change only in the clock after a header pulse or an elementary-stream update. Table writes in between leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Table word write strobe |
| cfg_addr | input | 3 | Table word address |
| cfg_wdata | input | 16 | Table word data |
| hdr_valid | input | 1 | Header fields of a new packet are present |
| hdr_pid | input | 13 | Packet identifier |
| hdr_tsc | input | 2 | Transport scrambling bits |
| hdr_pusi | input | 1 | Payload-start flag |
| pes_valid | input | 1 | Elementary-stream scrambling bits are present |
| pes_sc | input | 2 | Elementary-stream scrambling bits |
| dsc_en | output | 1 | Payload is to be descrambled |
| dsc_pes | output | 1 | Descrambling is at elementary-stream level |
| key_sel | output | 3 | Key pair 0-5, or 6 for the default key |
| key_odd | output | 1 | Odd key of the pair selected |
| tsc_out | output | 2 | Rewritten transport scrambling bits |
| pes_sc_out | output | 2 | Rewritten elementary-stream scrambling bits |
| ts_sc_capt | output | 12 | Stored transport bits per entry |
| pes_sc_capt | output | 12 | Stored elementary-stream bits per entry |

## Verification
A wrong match vector or a wrong priority order shows up in the clock after the next header pulse, as a wrong key_sel or key_odd or a dsc_en that should not be set. A corrupted per-entry store stays hidden until a later packet without a payload start arrives for that entry. The bench therefore always follows a payload-start packet with such a packet and reads both capture vectors. A decision register that does not hold its value shows up as soon as idle cycles or table writes pass between packets.

// File: rtl/csel_pkg.sv
// Shared constants and encodings for the packet key-selection unit.
// Assumes six table entries, 13-bit identifiers and 3-bit pair pointers.
package csel_pkg;
    localparam int NUM_PID = 6;
    localparam int PID_W   = 13;
    localparam int CWPI_W  = 3;
    localparam int SC_W    = 2;
    localparam int CFG_DW  = 16;

    // key_sel value that names the default key
    localparam logic [CWPI_W-1:0] KEY_DEFAULT = 3'd6;

    typedef enum logic [SC_W-1:0] {
        SC_CLEAR   = 2'b00,
        SC_DEFAULT = 2'b01,
        SC_EVEN    = 2'b10,
        SC_ODD     = 2'b11
    } sc_e;
endpackage

// File: rtl/csel_cfg_regs.sv
// Holds the identifier table, the pair pointers, the mask of the last
// entry, the elementary-stream flags and the default-valid flag.
// Assumes one word write per strobe; a write is visible in the next cycle.
module csel_cfg_regs #(
    parameter int NUM    = 6,
    parameter int PID_W  = 13,
    parameter int CWPI_W = 3,
    parameter int DW     = 16,
    parameter int AW     = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_wr,
    input  logic [AW-1:0]                 cfg_addr,
    input  logic [DW-1:0]                 cfg_wdata,
    output logic [NUM-1:0][PID_W-1:0]     pid_tab,
    output logic [NUM-1:0][CWPI_W-1:0]    cwpi_tab,
    output logic [PID_W-1:0]              pid_mask,
    output logic [NUM-1:0]                is_pes,
    output logic                          dcw_valid
);
    localparam int MASK_ADDR = NUM;
    localparam int GLOB_ADDR = NUM + 1;

    // Table storage with reset values and word writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pid_tab   <= '0;
            cwpi_tab  <= '1;
            pid_mask  <= '1;
            is_pes    <= '0;
            dcw_valid <= 1'b0;
        end else if (cfg_wr) begin
            for (int i = 0; i < NUM; i++) begin
                if (cfg_addr == AW'(i)) begin
                    pid_tab[i]  <= cfg_wdata[PID_W-1:0];
                    cwpi_tab[i] <= cfg_wdata[PID_W +: CWPI_W];
                end
            end
            if (cfg_addr == AW'(MASK_ADDR))
                pid_mask <= cfg_wdata[PID_W-1:0];
            if (cfg_addr == AW'(GLOB_ADDR)) begin
                is_pes    <= cfg_wdata[NUM-1:0];
                dcw_valid <= cfg_wdata[DW-1];
            end
        end
    end
endmodule

// File: rtl/csel_pid_match.sv
// Compares one identifier against every table entry. The last entry
// compares only the bits whose mask bit is 1. Purely combinational.
module csel_pid_match #(
    parameter int NUM   = 6,
    parameter int PID_W = 13
) (
    input  logic [PID_W-1:0]            pid_in,
    input  logic [NUM-1:0][PID_W-1:0]   pid_tab,
    input  logic [PID_W-1:0]            pid_mask,
    output logic [NUM-1:0]              hit
);
    for (genvar g = 0; g < NUM; g++) begin : g_cmp
        if (g == NUM - 1) begin : g_masked
            // Masked compare for the last entry
            assign hit[g] = ((pid_in ^ pid_tab[g]) & pid_mask) == '0;
        end else begin : g_exact
            // Exact compare for the other entries
            assign hit[g] = (pid_in == pid_tab[g]);
        end
    end
endmodule

// File: rtl/csel_prio.sv
// Fixed-priority pick: the lowest set request bit wins.
// Assumes IDX_W is wide enough to hold NUM-1.
module csel_prio #(
    parameter int NUM   = 6,
    parameter int IDX_W = 3
) (
    input  logic [NUM-1:0]   req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so that the lowest index is assigned last
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/pid_cw_selector.sv
// Per-packet key selection. It matches the header identifier against
// the table, applies the default-key override and the precedence of the
// transport level over the elementary-stream level, and registers the
// decision. It also stores the scrambling bits per entry and rewrites
// the outgoing scrambling bits.
// Assumes: hdr_valid is a one-cycle pulse per packet. pes_valid arrives
// after hdr_valid inside the same packet. When both are high together,
// hdr_valid wins.
module pid_cw_selector
    import csel_pkg::*;
#(
    parameter int NUM_PID = csel_pkg::NUM_PID,
    parameter int PID_W   = csel_pkg::PID_W,
    parameter int CWPI_W  = csel_pkg::CWPI_W,
    parameter int SC_W    = csel_pkg::SC_W,
    parameter int CFG_DW  = csel_pkg::CFG_DW,
    parameter int CFG_AW  = $clog2(NUM_PID + 2)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_wr,
    input  logic [CFG_AW-1:0]         cfg_addr,
    input  logic [CFG_DW-1:0]         cfg_wdata,
    input  logic                      hdr_valid,
    input  logic [PID_W-1:0]          hdr_pid,
    input  logic [SC_W-1:0]           hdr_tsc,
    input  logic                      hdr_pusi,
    input  logic                      pes_valid,
    input  logic [SC_W-1:0]           pes_sc,
    output logic                      dsc_en,
    output logic                      dsc_pes,
    output logic [CWPI_W-1:0]         key_sel,
    output logic                      key_odd,
    output logic [SC_W-1:0]           tsc_out,
    output logic [SC_W-1:0]           pes_sc_out,
    output logic [NUM_PID*SC_W-1:0]   ts_sc_capt,
    output logic [NUM_PID*SC_W-1:0]   pes_sc_capt
);
    localparam int IDX_W = $clog2(NUM_PID);

    logic [NUM_PID-1:0][PID_W-1:0]  pid_tab;
    logic [NUM_PID-1:0][CWPI_W-1:0] cwpi_tab;
    logic [PID_W-1:0]               pid_mask;
    logic [NUM_PID-1:0]             is_pes;
    logic                           dcw_valid;

    logic [NUM_PID-1:0]             hit;
    logic [NUM_PID-1:0]             cand;
    logic                           win_any;
    logic [IDX_W-1:0]               win_idx;
    logic [CWPI_W-1:0]              win_key;
    logic                           win_pes;
    logic [SC_W-1:0]                win_pes_sc;

    logic [NUM_PID-1:0][SC_W-1:0]   ts_cap;
    logic [NUM_PID-1:0][SC_W-1:0]   pes_cap;

    // Packet state held from the header pulse
    logic                           cur_pusi;
    logic [SC_W-1:0]                cur_tsc;
    logic [NUM_PID-1:0]             cur_hit;
    logic                           cur_win_any;
    logic [IDX_W-1:0]               cur_win_idx;
    logic [CWPI_W-1:0]              cur_key;

    logic                           h_en, h_pes, h_odd;
    logic [CWPI_W-1:0]              h_key;
    logic                           p_ok, p_en;

    csel_cfg_regs #(
        .NUM(NUM_PID), .PID_W(PID_W), .CWPI_W(CWPI_W), .DW(CFG_DW), .AW(CFG_AW)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pid_tab(pid_tab), .cwpi_tab(cwpi_tab),
        .pid_mask(pid_mask), .is_pes(is_pes), .dcw_valid(dcw_valid)
    );

    csel_pid_match #(.NUM(NUM_PID), .PID_W(PID_W)) u_match (
        .pid_in(hdr_pid), .pid_tab(pid_tab), .pid_mask(pid_mask), .hit(hit)
    );

    // An entry competes only if its pointer names a real key pair
    always_comb begin
        for (int i = 0; i < NUM_PID; i++)
            cand[i] = hit[i] && (cwpi_tab[i] < CWPI_W'(NUM_PID));
    end

    csel_prio #(.NUM(NUM_PID), .IDX_W(IDX_W)) u_prio (
        .req(cand), .any(win_any), .idx(win_idx)
    );

    // Attributes of the winning entry
    always_comb begin
        win_key    = '0;
        win_pes    = 1'b0;
        win_pes_sc = '0;
        for (int i = 0; i < NUM_PID; i++) begin
            if (win_any && win_idx == IDX_W'(i)) begin
                win_key    = cwpi_tab[i];
                win_pes    = is_pes[i];
                win_pes_sc = pes_cap[i];
            end
        end
    end

    // Decision from the header fields: default key, transport level, then stored stream bits
    always_comb begin
        h_en  = 1'b0;
        h_pes = 1'b0;
        h_key = '0;
        h_odd = 1'b0;
        case (sc_e'(hdr_tsc))
            SC_DEFAULT: begin
                if (dcw_valid) begin
                    h_en  = 1'b1;
                    h_key = KEY_DEFAULT;
                end
            end
            SC_EVEN, SC_ODD: begin
                if (win_any) begin
                    h_en  = 1'b1;
                    h_key = win_key;
                    h_odd = hdr_tsc[0];
                end
            end
            default: begin
                if (win_any && win_pes && !hdr_pusi && win_pes_sc[1]) begin
                    h_en  = 1'b1;
                    h_pes = 1'b1;
                    h_key = win_key;
                    h_odd = win_pes_sc[0];
                end
            end
        endcase
    end

    // Decision from elementary-stream bits arriving inside a payload-start packet
    always_comb begin
        p_ok = 1'b0;
        for (int i = 0; i < NUM_PID; i++)
            if (cur_win_any && cur_win_idx == IDX_W'(i) && is_pes[i])
                p_ok = pes_valid && cur_pusi && (cur_tsc == SC_CLEAR);
        p_en = p_ok && pes_sc[1];
    end

    // Registered decision and rewritten scrambling bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsc_en     <= 1'b0;
            dsc_pes    <= 1'b0;
            key_sel    <= '0;
            key_odd    <= 1'b0;
            tsc_out    <= '0;
            pes_sc_out <= '0;
        end else if (hdr_valid) begin
            dsc_en     <= h_en;
            dsc_pes    <= h_pes;
            key_sel    <= h_key;
            key_odd    <= h_odd;
            tsc_out    <= (h_en && !h_pes) ? SC_CLEAR : hdr_tsc;
            pes_sc_out <= '0;
        end else if (pes_valid && cur_pusi) begin
            if (p_ok) begin
                dsc_en  <= p_en;
                dsc_pes <= p_en;
                key_sel <= p_en ? cur_key : '0;
                key_odd <= p_en && pes_sc[0];
            end
            pes_sc_out <= p_en ? SC_CLEAR : pes_sc;
        end
    end

    // Packet context held for the stream-level update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_pusi    <= 1'b0;
            cur_tsc     <= '0;
            cur_hit     <= '0;
            cur_win_any <= 1'b0;
            cur_win_idx <= '0;
            cur_key     <= '0;
        end else if (hdr_valid) begin
            cur_pusi    <= hdr_pusi;
            cur_tsc     <= hdr_tsc;
            cur_hit     <= hit;
            cur_win_any <= win_any;
            cur_win_idx <= win_idx;
            cur_key     <= win_key;
        end
    end

    // Per-entry store of the scrambling bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_cap  <= '0;
            pes_cap <= '0;
        end else if (hdr_valid) begin
            for (int i = 0; i < NUM_PID; i++)
                if (hit[i]) ts_cap[i] <= hdr_tsc;
        end else if (pes_valid && cur_pusi) begin
            for (int i = 0; i < NUM_PID; i++)
                if (cur_hit[i] && is_pes[i]) pes_cap[i] <= pes_sc;
        end
    end

    assign ts_sc_capt  = ts_cap;
    assign pes_sc_capt = pes_cap;
endmodule

// File: rtl/pid_cw_selector_chk.sv
// Property checker for the key-selection unit, attached by bind.
module pid_cw_selector_chk
    import csel_pkg::*;
#(
    parameter int CWPI_W = csel_pkg::CWPI_W,
    parameter int SC_W   = csel_pkg::SC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hdr_valid,
    input logic [SC_W-1:0]   hdr_tsc,
    input logic              pes_valid,
    input logic              dcw_valid,
    input logic              dsc_en,
    input logic              dsc_pes,
    input logic [CWPI_W-1:0] key_sel,
    input logic              key_odd,
    input logic [SC_W-1:0]   tsc_out
);
    assert_dcw_pick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && hdr_tsc == 2'b01 && dcw_valid |=> dsc_en && !dsc_pes && key_sel == KEY_DEFAULT);

    assert_dcw_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && hdr_tsc == 2'b01 && !dcw_valid |=> !dsc_en);

    assert_clear_ts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && hdr_tsc == 2'b00 |=> !dsc_en || dsc_pes);

    assert_key_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_en |-> key_sel <= KEY_DEFAULT);

    assert_tsc_rewrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_en && !dsc_pes |-> tsc_out == 2'b00);

    assert_pes_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_pes |-> dsc_en && tsc_out == 2'b00 && key_sel != KEY_DEFAULT);

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid && !pes_valid |=> $stable(dsc_en) && $stable(key_sel) && $stable(key_odd));
endmodule

bind pid_cw_selector pid_cw_selector_chk #(.CWPI_W(CWPI_W), .SC_W(SC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_tsc(hdr_tsc),
    .pes_valid(pes_valid), .dcw_valid(dcw_valid), .dsc_en(dsc_en),
    .dsc_pes(dsc_pes), .key_sel(key_sel), .key_odd(key_odd), .tsc_out(tsc_out)
);

// File: tb/pid_cw_selector_tb.sv
// Directed bench for the key-selection unit, one task per scenario.
module pid_cw_selector_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        hdr_valid = 1'b0;
    logic [12:0] hdr_pid = '0;
    logic [1:0]  hdr_tsc = '0;
    logic        hdr_pusi = 1'b0;
    logic        pes_valid = 1'b0;
    logic [1:0]  pes_sc = '0;
    logic        dsc_en, dsc_pes, key_odd;
    logic [2:0]  key_sel;
    logic [1:0]  tsc_out, pes_sc_out;
    logic [11:0] ts_sc_capt, pes_sc_capt;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pid_cw_selector u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .hdr_valid(hdr_valid), .hdr_pid(hdr_pid),
        .hdr_tsc(hdr_tsc), .hdr_pusi(hdr_pusi), .pes_valid(pes_valid),
        .pes_sc(pes_sc), .dsc_en(dsc_en), .dsc_pes(dsc_pes), .key_sel(key_sel),
        .key_odd(key_odd), .tsc_out(tsc_out), .pes_sc_out(pes_sc_out),
        .ts_sc_capt(ts_sc_capt), .pes_sc_capt(pes_sc_capt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Decision bundle {en, pes, key, odd}
    function automatic logic [5:0] dec();
        return {dsc_en, dsc_pes, key_sel, key_odd};
    endfunction

    task automatic cfg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic hdr(input logic [12:0] pid, input logic [1:0] tsc, input logic pusi);
        @(negedge clk);
        hdr_valid = 1'b1; hdr_pid = pid; hdr_tsc = tsc; hdr_pusi = pusi;
        @(negedge clk);
        hdr_valid = 1'b0;
    endtask

    task automatic pes(input logic [1:0] sc);
        @(negedge clk);
        pes_valid = 1'b1; pes_sc = sc;
        @(negedge clk);
        pes_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset decision", dec(), 6'b0);
        check("R1 reset ts capture", ts_sc_capt, 12'h000);
        hdr(13'h000, 2'b10, 1'b0);
        check("R1 no descramble after reset", dec(), 6'b0);
        check("R10 tsc passthrough", tsc_out, 2'b10);
        check("R9 capture regardless of pointer", ts_sc_capt, 12'hAAA);
    endtask

    task automatic t_load();
        cfg(3'd0, {3'd2, 13'h0100});
        cfg(3'd1, {3'd4, 13'h0100});
        cfg(3'd2, {3'd7, 13'h0200});
        cfg(3'd3, {3'd1, 13'h0200});
        cfg(3'd4, {3'd0, 13'h0300});
        cfg(3'd5, {3'd5, 13'h1A00});
    endtask

    task automatic t_priority();
        hdr(13'h0100, 2'b11, 1'b0);
        check("R4 lowest entry wins odd", dec(), {1'b1, 1'b0, 3'd2, 1'b1});
        check("R9 both matches captured", ts_sc_capt, 12'hAAF);
        hdr(13'h0200, 2'b10, 1'b0);
        check("R3 disabled entry skipped", dec(), {1'b1, 1'b0, 3'd1, 1'b0});
        check("R10 tsc rewritten", tsc_out, 2'b00);
    endtask

    task automatic t_sc_codes();
        hdr(13'h0300, 2'b00, 1'b0);
        check("R5 clear packet", dec(), 6'b0);
        hdr(13'h0300, 2'b10, 1'b0);
        check("R5 even key pair0", dec(), {1'b1, 1'b0, 3'd0, 1'b0});
        hdr(13'h0555, 2'b10, 1'b0);
        check("R5 unmatched pid clear", dec(), 6'b0);
    endtask

    task automatic t_mask();
        hdr(13'h1A01, 2'b10, 1'b0);
        check("R2 full mask exact", dsc_en, 1'b0);
        cfg(3'd6, 16'h1FF0);
        hdr(13'h1A07, 2'b11, 1'b0);
        check("R2 masked match", dec(), {1'b1, 1'b0, 3'd5, 1'b1});
        hdr(13'h1B07, 2'b11, 1'b0);
        check("R2 unmasked bit differs", dsc_en, 1'b0);
        hdr(13'h0107, 2'b10, 1'b0);
        check("R2 entry0 exact only", dsc_en, 1'b0);
    endtask

    task automatic t_default();
        hdr(13'h0999, 2'b01, 1'b0);
        check("R6 default invalid", dsc_en, 1'b0);
        check("R10 tsc kept when clear", tsc_out, 2'b01);
        cfg(3'd7, 16'h8000);
        hdr(13'h0999, 2'b01, 1'b0);
        check("R6 default unprogrammed pid", dec(), {1'b1, 1'b0, 3'd6, 1'b0});
        hdr(13'h0100, 2'b01, 1'b0);
        check("R6 default overrides entry", dec(), {1'b1, 1'b0, 3'd6, 1'b0});
    endtask

    task automatic t_hold();
        hdr(13'h0100, 2'b10, 1'b0);
        cfg(3'd0, {3'd3, 13'h0100});
        repeat (3) @(negedge clk);
        check("R11 held across writes", dec(), {1'b1, 1'b0, 3'd2, 1'b0});
        hdr(13'h0100, 2'b10, 1'b0);
        check("R11 new packet uses new pointer", dec(), {1'b1, 1'b0, 3'd3, 1'b0});
    endtask

    task automatic t_pes();
        cfg(3'd7, 16'h8010);
        hdr(13'h0300, 2'b00, 1'b1);
        check("R8 clear until stream bits", dsc_en, 1'b0);
        pes(2'b10);
        check("R7 stream level even", dec(), {1'b1, 1'b1, 3'd0, 1'b0});
        check("R10 stream bits rewritten", pes_sc_out, 2'b00);
        check("R8 stream bits stored", pes_sc_capt, 12'h200);
        hdr(13'h0300, 2'b00, 1'b0);
        check("R8 stored bits reused", dec(), {1'b1, 1'b1, 3'd0, 1'b0});
        hdr(13'h0300, 2'b00, 1'b1);
        pes(2'b01);
        check("R7 stream 01 clear", dsc_en, 1'b0);
        check("R10 stream bits passthrough", pes_sc_out, 2'b01);
        check("R8 stored 01", pes_sc_capt, 12'h100);
        hdr(13'h0300, 2'b00, 1'b0);
        check("R7 stored clear reused", dsc_en, 1'b0);
        hdr(13'h0300, 2'b00, 1'b1);
        pes(2'b11);
        check("R7 stream level odd", dec(), {1'b1, 1'b1, 3'd0, 1'b1});
        hdr(13'h0300, 2'b11, 1'b0);
        check("R7 transport precedence", dec(), {1'b1, 1'b0, 3'd0, 1'b1});
        hdr(13'h0100, 2'b00, 1'b0);
        check("R7 flag clear entry", dsc_en, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_priority();
        t_sc_codes();
        t_mask();
        t_default();
        t_hold();
        t_pes();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule